// File: doc/BRIEF.md
# Non-volatile memory word access register

This block is a host-visible register pair placed in front of a non-volatile memory that holds 16-bit words. The host writes a byte address into the address field of the access register, and that write starts one word read on a simple memory port. The memory answers after a variable number of cycles. When it answers, the block stores the returned word in the upper half of the access register and sets a completion flag in bit 0 of the same register. The host polls that flag and then takes the data from the upper half.

The memory model also reports the error-correction outcome of each read on two input flags. The block records each outcome in its own sticky bit of a separate status register, and the host clears a bit by writing one to it. A read that ends with an uncorrectable error counts as failed: its completion flag still rises, but the data field reads as zero. A read with a correctable error delivers its data normally.

Top module: `nvm_word_access`

## Requirements
- R1: After reset the completion flag, the data field (access bits 31:16), the address field and both status flags read as zero, and `mem_req` is low.
- R2: A host write with `host_sel`=0 loads access bits ADDR_W:1 (the word's byte address, shifted left one bit by the host) into the address field and starts a read. From the next cycle `mem_req` is high, `mem_addr` equals the field, and the completion flag reads 0.
- R3: While `mem_req` is high and `mem_ready` is low, `mem_req` stays high and `mem_addr` does not change.
- R4: In the cycle after `mem_ready` is seen with `mem_req` high, access bit 0 reads 1 and access bits 31:16 hold the word from `mem_rdata` (unless R7 applies), and `mem_req` is low.
- R5: For any memory latency from 1 to 63 cycles the completion flag stays 0 until the cycle after `mem_ready`.
- R6: An access-register write made while a read is in flight is ignored: the address and the returned word are those of the first request.
- R7: A completion with `mem_ecc_unc` high sets status bit 0 (uncorrectable) and leaves access bits 31:16 at zero while the completion flag reads 1.
- R8: A completion with `mem_ecc_corr` high sets status bit 1 (correctable) and still delivers the word in access bits 31:16.
- R9: A host write with `host_sel`=1 clears each status bit written as one and leaves bits written as zero; a flag being set in the same cycle as its clear stays set.
- R10: Starting a new read clears the completion flag; the data field keeps the previous word until the new read completes.
- R11: `host_rdata` shows the access register when `host_sel`=0 and the status register (bit 0 uncorrectable, bit 1 correctable, other bits zero) when `host_sel`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | Register select: 0 access, 1 status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Read request to the memory, held until ready |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_ready | input | 1 | Memory answer strobe, one cycle |
| mem_rdata | input | 16 | Word returned with `mem_ready` |
| mem_ecc_corr | input | 1 | Correctable error seen on this answer |
| mem_ecc_unc | input | 1 | Uncorrectable error seen on this answer |

## Verification
On every cycle the assertions check the request handshake (request held and address steady until the answer), that the completion flag never rises without an answer in the previous cycle, that captured data matches the answer or is zero on a failed read, and that each error flag sets on its outcome and clears on a one-write. Only the bench scenarios show the host-level picture: the register layout seen through `host_rdata`, a busy-time write being dropped with the original word still returned, latencies at both ends of the range, and the same-cycle set-versus-clear ordering of the status flags.

// File: rtl/nvm_acc_pkg.sv
package nvm_acc_pkg;

    localparam int REG_W      = 32;
    localparam int WORD_W     = 16;
    localparam int DONE_BIT   = 0;
    localparam int WORD_LSB   = 16;
    localparam int FLAG_UNC   = 0;
    localparam int FLAG_CORR  = 1;

    typedef enum logic {
        SEL_ACCESS = 1'b0,
        SEL_STATUS = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic corr;
        logic unc;
    } ecc_flags_t;

endpackage

// File: rtl/nvm_acc_launch.sv
module nvm_acc_launch
    import nvm_acc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ecc_unc,
    output logic              done,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [WORD_W-1:0] word,
    output logic              answer
);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] word;
    } lch_t;

    lch_t st_d, st_q;
    logic accept;
    logic finish;

    always_comb begin
        st_d   = st_q;
        accept = start_wr && !st_q.busy;
        finish = st_q.busy && mem_ready;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.done = 1'b0;
            st_d.addr = start_addr;
        end else if (finish) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.word = mem_ecc_unc ? '0 : mem_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req  = st_q.busy;
    assign mem_addr = st_q.addr;
    assign done     = st_q.done;
    assign cur_addr = st_q.addr;
    assign word     = st_q.word;
    assign answer   = finish;

    // R3: request held until the memory answers
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> mem_req);

    // R3: address steady across the wait
    a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> $stable(mem_addr));

    // R5: completion only follows an answer
    a_r5_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_ready && mem_req));

    // R4: captured word matches the answer
    a_r4_word_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_ecc_unc) |=> (word == $past(mem_rdata) && done && !mem_req));

    // R7: failed read leaves zero
    a_r7_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_ecc_unc) |=> (word == '0 && done));

    // R10: no completion shown while a read is pending
    a_r10_done_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !done);

endmodule

// File: rtl/nvm_acc_ecc.sv
module nvm_acc_ecc
    import nvm_acc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       answer,
    input  logic       ecc_corr,
    input  logic       ecc_unc,
    input  logic       clr_wr,
    input  ecc_flags_t clr_mask,
    output ecc_flags_t flags
);

    ecc_flags_t fl_d, fl_q;
    ecc_flags_t hit;

    always_comb begin
        hit.corr = answer && ecc_corr;
        hit.unc  = answer && ecc_unc;
        fl_d     = fl_q;
        if (clr_wr) begin
            fl_d.corr = fl_q.corr && !clr_mask.corr;
            fl_d.unc  = fl_q.unc && !clr_mask.unc;
        end
        fl_d.corr = fl_d.corr || hit.corr;
        fl_d.unc  = fl_d.unc || hit.unc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q;

    // R7: uncorrectable outcome is recorded
    a_r7_unc_set: assert property (@(posedge clk) disable iff (!rst_n)
        (answer && ecc_unc) |=> flags.unc);

    // R8: correctable outcome is recorded
    a_r8_corr_set: assert property (@(posedge clk) disable iff (!rst_n)
        (answer && ecc_corr) |=> flags.corr);

    // R9: one-write clears when nothing sets
    a_r9_unc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask.unc && !(answer && ecc_unc)) |=> !flags.unc);

    a_r9_corr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask.corr && !(answer && ecc_corr)) |=> !flags.corr);

    // R9: flags are sticky without a one-write
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr && flags.unc) |=> flags.unc);

endmodule

// File: rtl/nvm_acc_readback.sv
module nvm_acc_readback
    import nvm_acc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  reg_sel_e          sel,
    input  logic              done,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [WORD_W-1:0] word,
    input  ecc_flags_t        flags,
    output logic [REG_W-1:0]  rdata
);

    localparam int PAD_W = WORD_LSB - 1 - ADDR_W;

    logic [REG_W-1:0] acc_view;
    logic [REG_W-1:0] stat_view;

    generate
        if (PAD_W > 0) begin : g_pad
            assign acc_view = {word, {PAD_W{1'b0}}, cur_addr, done};
        end else begin : g_nopad
            assign acc_view = {word, cur_addr, done};
        end
    endgenerate

    always_comb begin
        stat_view            = '0;
        stat_view[FLAG_UNC]  = flags.unc;
        stat_view[FLAG_CORR] = flags.corr;
    end

    assign rdata = (sel == SEL_STATUS) ? stat_view : acc_view;

endmodule

// File: rtl/nvm_word_access.sv
module nvm_word_access
    import nvm_acc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ecc_corr,
    input  logic              mem_ecc_unc
);

    reg_sel_e          sel;
    logic              acc_wr;
    logic              stat_wr;
    logic              done;
    logic              answer;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] word;
    ecc_flags_t        flags;
    ecc_flags_t        clr_mask;

    assign sel           = reg_sel_e'(host_sel);
    assign acc_wr        = host_wr && (sel == SEL_ACCESS);
    assign stat_wr       = host_wr && (sel == SEL_STATUS);
    assign clr_mask.unc  = host_wdata[FLAG_UNC];
    assign clr_mask.corr = host_wdata[FLAG_CORR];

    nvm_acc_launch #(.ADDR_W(ADDR_W)) u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_wr   (acc_wr),
        .start_addr (host_wdata[ADDR_W:1]),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .mem_ecc_unc(mem_ecc_unc),
        .done       (done),
        .cur_addr   (cur_addr),
        .word       (word),
        .answer     (answer)
    );

    nvm_acc_ecc u_ecc (
        .clk      (clk),
        .rst_n    (rst_n),
        .answer   (answer),
        .ecc_corr (mem_ecc_corr),
        .ecc_unc  (mem_ecc_unc),
        .clr_wr   (stat_wr),
        .clr_mask (clr_mask),
        .flags    (flags)
    );

    nvm_acc_readback #(.ADDR_W(ADDR_W)) u_rb (
        .sel      (sel),
        .done     (done),
        .cur_addr (cur_addr),
        .word     (word),
        .flags    (flags),
        .rdata    (host_rdata)
    );

    // R1: nothing requested straight out of reset
    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (!mem_req && host_rdata[0] == 1'b0));

    // R2: accepted write raises request with the written address
    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !mem_req) |=> (mem_req && mem_addr == $past(host_wdata[ADDR_W:1])));

endmodule

// File: tb/nvm_word_access_test.sv
module nvm_word_access_test;

    localparam int PERIOD = 10;
    localparam int AW     = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_sel = 1'b0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ready = 1'b0;
    logic [15:0]   mem_rdata = '0;
    logic          mem_ecc_corr = 1'b0;
    logic          mem_ecc_unc = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    int   lat = 1;
    logic m_corr = 1'b0;
    logic m_unc = 1'b0;
    int   cnt = 0;

    always #(PERIOD/2) clk = ~clk;

    nvm_word_access #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .mem_ecc_corr(mem_ecc_corr), .mem_ecc_unc(mem_ecc_unc)
    );

    function automatic logic [15:0] word_of(input logic [AW-1:0] a);
        return {4'h0, a} ^ 16'hA5C3;
    endfunction

    // memory model: answers lat cycles after the request is first seen
    always @(posedge clk) begin
        if (mem_ready) begin
            mem_ready    <= 1'b0;
            mem_ecc_corr <= 1'b0;
            mem_ecc_unc  <= 1'b0;
            cnt          <= 0;
        end else if (mem_req) begin
            if (cnt + 1 == lat) begin
                mem_ready    <= 1'b1;
                mem_rdata    <= word_of(mem_addr);
                mem_ecc_corr <= m_corr;
                mem_ecc_unc  <= m_unc;
            end
            cnt <= cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [31:0] d);
        host_sel   = sel;
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
        host_sel   = 1'b0;
    endtask

    task automatic read_reg(input logic sel, output logic [31:0] d);
        host_sel = sel;
        #1;
        d = host_rdata;
        host_sel = 1'b0;
        #1;
    endtask

    // waits for the answer, checking the flag stays low on the way
    task automatic wait_answer(input logic [AW-1:0] a, input string req);
        logic [31:0] r;
        int guard;
        guard = 0;
        while (!mem_ready && guard < 100) begin
            read_reg(1'b0, r);
            check(req, {31'b0, r[0]}, 32'd0);
            check("R3", {mem_req, 19'b0, mem_addr}, {1'b1, 19'b0, a});
            @(negedge clk);
            guard++;
        end
        read_reg(1'b0, r);
        check(req, {31'b0, r[0]}, 32'd0);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] r;
        read_reg(1'b0, r);
        check("R1", r, 32'd0);
        read_reg(1'b1, r);
        check("R1", r, 32'd0);
        check("R1", {31'b0, mem_req}, 32'd0);
    endtask

    task automatic t_plain(input logic [AW-1:0] a, input int l);
        logic [31:0] r;
        lat = l; m_corr = 1'b0; m_unc = 1'b0;
        host_write(1'b0, {19'b0, a, 1'b0});
        read_reg(1'b0, r);
        check("R2", {mem_req, 15'b0, 4'b0, r[AW:1]}, {1'b1, 15'b0, 4'b0, a});
        check("R10", {31'b0, r[0]}, 32'd0);
        wait_answer(a, "R5");
        read_reg(1'b0, r);
        check("R4", {r[31:16], 15'b0, r[0]}, {word_of(a), 15'b0, 1'b1});
        check("R4", {31'b0, mem_req}, 32'd0);
    endtask

    task automatic t_keep_word;
        logic [31:0] r;
        lat = 5;
        host_write(1'b0, {19'b0, 12'h0AA, 1'b0});
        read_reg(1'b0, r);
        check("R10", {r[31:16], 15'b0, r[0]}, {word_of(12'h123), 16'b0});
        wait_answer(12'h0AA, "R5");
        read_reg(1'b0, r);
        check("R10", r[31:16], {16'b0, word_of(12'h0AA)} >> 0 & 32'hFFFF);
    endtask

    task automatic t_busy_write;
        logic [31:0] r;
        lat = 20;
        host_write(1'b0, {19'b0, 12'h3C0, 1'b0});
        @(negedge clk);
        @(negedge clk);
        host_write(1'b0, {19'b0, 12'h555, 1'b0});
        check("R6", {20'b0, mem_addr}, {20'b0, 12'h3C0});
        wait_answer(12'h3C0, "R6");
        read_reg(1'b0, r);
        check("R6", {r[31:16], 4'b0, r[AW:1]}, {word_of(12'h3C0), 4'b0, 12'h3C0});
    endtask

    task automatic t_unc;
        logic [31:0] r;
        lat = 3; m_unc = 1'b1; m_corr = 1'b0;
        host_write(1'b0, {19'b0, 12'h010, 1'b0});
        wait_answer(12'h010, "R7");
        read_reg(1'b0, r);
        check("R7", {r[31:16], 15'b0, r[0]}, {16'b0, 15'b0, 1'b1});
        read_reg(1'b1, r);
        check("R7", r, 32'h1);
        m_unc = 1'b0;
    endtask

    task automatic t_corr;
        logic [31:0] r;
        lat = 2; m_corr = 1'b1;
        host_write(1'b0, {19'b0, 12'h020, 1'b0});
        wait_answer(12'h020, "R8");
        read_reg(1'b0, r);
        check("R8", {r[31:16], 15'b0, r[0]}, {word_of(12'h020), 15'b0, 1'b1});
        read_reg(1'b1, r);
        check("R8", r, 32'h3);
        m_corr = 1'b0;
    endtask

    task automatic t_clear;
        logic [31:0] r;
        host_write(1'b1, 32'h0);
        read_reg(1'b1, r);
        check("R9", r, 32'h3);
        host_write(1'b1, 32'h1);
        read_reg(1'b1, r);
        check("R9", r, 32'h2);
        host_write(1'b1, 32'h2);
        read_reg(1'b1, r);
        check("R9", r, 32'h0);
        read_reg(1'b0, r);
        check("R11", {31'b0, r[0]}, 32'd1);
    endtask

    // clear written in the same cycle the flag is set
    task automatic t_set_wins;
        logic [31:0] r;
        lat = 1; m_unc = 1'b1;
        host_write(1'b0, {19'b0, 12'h044, 1'b0});
        @(negedge clk);
        host_write(1'b1, 32'h1);
        read_reg(1'b1, r);
        check("R9", r, 32'h1);
        m_unc = 1'b0;
        host_write(1'b1, 32'h1);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain(12'h123, 1);
        t_keep_word();
        t_plain(12'hFFE, 63);
        t_plain(12'h002, 7);
        t_plain(12'h123, 2);
        t_busy_write();
        t_unc();
        t_corr();
        t_clear();
        t_set_wins();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule